// File: doc/BRIEF.md
# Backplane System Controller: Bus Arbiter, Bus-Error Timer and Reset Driver

This block carries out the system-controller duty on a bus shared by several masters. Masters request the bus on one of four request levels. The controller waits until the bus is no longer busy and then grants one level. It picks that level round-robin, so every level gets a turn. Daisy-chain passing inside a level is handled outside the block. The grant stays on until the new owner takes the bus by asserting busy.

The same block times each slave access. When a data strobe goes unanswered for the selected number of microsecond ticks, it raises bus error. It also drives the backplane reset whenever the local board is reset, and holds that reset for a minimum number of clocks. The whole function is switched on by a hardware strap that software cannot write, and the strap state is reflected on a status output that software can read.

Top module: `bsc_sysctl`

## Requirements
- R1: With the enable strap high, `bus_reset_o` is high while `rst_n` is low and for exactly RST_MIN clocks after `rst_n` rises. It is also high for exactly RST_MIN clocks after the last cycle in which `lreset_req_i` was sampled high.
- R2: With the enable strap low, no grant, bus error or bus reset is produced. `sysctl_on_o` always equals the strap.
- R3: At most one grant bit is high at any time. A new grant appears one clock after a cycle in which busy is low, a request is pending and the bus reset is not active. No grant is issued while busy is high or during a bus reset.
- R4: A grant stays high until busy is sampled high, or until the granted level drops its request. It falls on the next clock after either event.
- R5: Levels are served round-robin, and bit k of `req_i`/`grant_o` is level k. The search starts at the level after the one granted last. After reset it starts at level 3.
- R6: With `single_lvl_i` high, only level 3 (bit 3) can be granted, and requests on levels 0 to 2 are ignored.
- R7: When `tmo_sel_i` is s, with s from 0 to 6, bus error rises one clock after the (16·2^s)-th tick counted while the strobe is high and no acknowledge is given.
- R8: When `tmo_sel_i` is 7, bus error is never raised.
- R9: Bus error stays high until the strobe falls and clears on the next clock. A new strobe restarts the tick count from zero.
- R10: Ticks that arrive while `sack_i` is high are not counted, so an access that is acknowledged in time never gets a bus error.
- R11: `arb_led_o` is high exactly while a grant is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Local reset, active low, asynchronous |
| en_strap_i | input | 1 | Hardware strap that enables the system controller |
| single_lvl_i | input | 1 | Strap: arbitrate level 3 only |
| tmo_sel_i | input | 3 | Timeout select: 16·2^s ticks for s = 0..6, disabled for 7 |
| lreset_req_i | input | 1 | Local reset request (synchronous) |
| req_i | input | 4 | Bus request per level (bit k is level k) |
| busy_i | input | 1 | Bus busy, driven by the current owner |
| dstrobe_i | input | 1 | Data strobe of a slave access, active high |
| sack_i | input | 1 | Slave acknowledge, active high |
| tick_i | input | 1 | One-clock pulse at 1 MHz |
| grant_o | output | 4 | Bus grant per level, one-hot or zero |
| berr_o | output | 1 | Bus error |
| bus_reset_o | output | 1 | Backplane reset |
| arb_led_o | output | 1 | Status: a grant is outstanding |
| sysctl_on_o | output | 1 | Readable state of the enable strap |

## Verification
The properties assume that the straps (`en_strap_i`, `single_lvl_i`, `tmo_sel_i`) are static during an access. They also assume that a master drops busy only after it has finished its tenure, and that `tick_i` is a single-clock pulse. The bench changes straps only while no strobe or grant is active. It drives busy with a take-then-release handshake after each grant and issues ticks as isolated one-clock pulses. All inputs change on the falling clock edge.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;

  // Tick count for a timeout selection; 0 means the timer is off.
  function automatic int unsigned tmo_ticks(input int unsigned sel,
                                            input int unsigned base,
                                            input int unsigned sel_w);
    if (sel == (32'd1 << sel_w) - 1) return 0;
    return base << sel;
  endfunction

  // Level following lvl, wrapping around n levels.
  function automatic int unsigned next_level(input int unsigned lvl,
                                             input int unsigned n);
    return (lvl + 1 == n) ? 0 : lvl + 1;
  endfunction

endpackage

// File: rtl/bsc_reset_stretch.sv
module bsc_reset_stretch #(
  parameter int RST_MIN = 8,
  localparam int W = $clog2(RST_MIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lreset_req_i,
  output logic hold_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= W'(RST_MIN);
    else if (lreset_req_i) cnt_q <= W'(RST_MIN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);

endmodule

// File: rtl/bsc_rr_arbiter.sv
module bsc_rr_arbiter
  import bsc_pkg::*;
#(
  parameter int N_LVL = 4,
  localparam int IW = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic             busy_i,
  input  logic [N_LVL-1:0] req_i,
  output logic [N_LVL-1:0] grant_o,
  output logic             fire_o,
  output logic             done_o
);

  arb_state_e       state_q;
  logic [N_LVL-1:0] grant_q;
  logic [IW-1:0]    ptr_q;
  logic [IW-1:0]    pick_idx;
  logic             pick_vld;

  always_comb begin : pick_blk
    int unsigned cand;
    pick_vld = 1'b0;
    pick_idx = '0;
    cand     = 0;
    for (int k = 0; k < N_LVL; k++) begin
      cand = (int'(ptr_q) + k) % N_LVL;
      if (!pick_vld && req_i[cand[IW-1:0]]) begin
        pick_vld = 1'b1;
        pick_idx = cand[IW-1:0];
      end
    end
  end

  assign fire_o = (state_q == ARB_IDLE) && en_i && !hold_i && !busy_i && pick_vld;
  assign done_o = (state_q == ARB_HELD) &&
                  (busy_i || ((req_i & grant_q) == '0) || hold_i || !en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
      ptr_q   <= IW'(N_LVL - 1);
    end else if (fire_o) begin
      state_q <= ARB_HELD;
      grant_q <= N_LVL'(1) << pick_idx;
      ptr_q   <= IW'(next_level(32'(pick_idx), N_LVL));
    end else if (done_o) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
    end
  end

  assign grant_o = grant_q;

endmodule

// File: rtl/bsc_bus_timer.sv
module bsc_bus_timer
  import bsc_pkg::*;
#(
  parameter int TMO_BASE = 16,
  parameter int SEL_W    = 3,
  localparam int MAX_TMO = TMO_BASE << ((1 << SEL_W) - 2),
  localparam int CW      = $clog2(MAX_TMO + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic             strobe_i,
  input  logic             ack_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             berr_o,
  output logic             hit_o
);

  logic          strobe_q;
  logic          berr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic [CW-1:0] base;
  logic [CW-1:0] nxt;
  logic          rise;
  logic          step;

  assign limit = CW'(tmo_ticks(32'(sel_i), TMO_BASE, SEL_W));
  assign rise  = strobe_i && !strobe_q;
  assign base  = rise ? '0 : cnt_q;
  assign step  = en_i && !hold_i && strobe_i && !ack_i && tick_i &&
                 !berr_q && (limit != '0);
  assign nxt   = base + CW'(step);
  assign hit_o = step && (nxt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      berr_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (!strobe_i || !en_i || hold_i) begin
        cnt_q  <= '0;
        berr_q <= 1'b0;
      end else begin
        cnt_q <= nxt;
        if (hit_o) berr_q <= 1'b1;
      end
    end
  end

  assign berr_o = berr_q;

endmodule

// File: rtl/bsc_sysctl.sv
module bsc_sysctl #(
  parameter int N_LVL    = 4,
  parameter int SEL_W    = 3,
  parameter int TMO_BASE = 16,
  parameter int RST_MIN  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_strap_i,
  input  logic             single_lvl_i,
  input  logic [SEL_W-1:0] tmo_sel_i,
  input  logic             lreset_req_i,
  input  logic [N_LVL-1:0] req_i,
  input  logic             busy_i,
  input  logic             dstrobe_i,
  input  logic             sack_i,
  input  logic             tick_i,
  output logic [N_LVL-1:0] grant_o,
  output logic             berr_o,
  output logic             bus_reset_o,
  output logic             arb_led_o,
  output logic             sysctl_on_o
);

  localparam logic [N_LVL-1:0] TOP_ONLY = N_LVL'(1) << (N_LVL - 1);

  // Named internal events
  logic             rst_hold;
  logic             arb_hold;
  logic             grant_fire;
  logic             grant_done;
  logic             tmo_hit;
  logic [N_LVL-1:0] req_eff;

  assign req_eff  = single_lvl_i ? (req_i & TOP_ONLY) : req_i;
  assign arb_hold = rst_hold | lreset_req_i;

  bsc_reset_stretch #(.RST_MIN(RST_MIN)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .lreset_req_i (lreset_req_i),
    .hold_o       (rst_hold)
  );

  bsc_rr_arbiter #(.N_LVL(N_LVL)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_strap_i),
    .hold_i  (arb_hold),
    .busy_i  (busy_i),
    .req_i   (req_eff),
    .grant_o (grant_o),
    .fire_o  (grant_fire),
    .done_o  (grant_done)
  );

  bsc_bus_timer #(.TMO_BASE(TMO_BASE), .SEL_W(SEL_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_strap_i),
    .hold_i   (arb_hold),
    .strobe_i (dstrobe_i),
    .ack_i    (sack_i),
    .tick_i   (tick_i),
    .sel_i    (tmo_sel_i),
    .berr_o   (berr_o),
    .hit_o    (tmo_hit)
  );

  assign bus_reset_o = en_strap_i & rst_hold;
  assign arb_led_o   = |grant_o;
  assign sysctl_on_o = en_strap_i;

endmodule

// File: rtl/bsc_sysctl_chk.sv
module bsc_sysctl_chk #(
  parameter int N_LVL = 4,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_strap_i,
  input logic             single_lvl_i,
  input logic [SEL_W-1:0] tmo_sel_i,
  input logic             lreset_req_i,
  input logic [N_LVL-1:0] req_i,
  input logic             busy_i,
  input logic             dstrobe_i,
  input logic             sack_i,
  input logic [N_LVL-1:0] grant_o,
  input logic             berr_o,
  input logic             bus_reset_o,
  input logic             arb_led_o,
  input logic             grant_fire,
  input logic             rst_hold
);

  AST_RST_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lreset_req_i && en_strap_i) |=> bus_reset_o); // R1

  AST_STRAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_strap_i |=> (grant_o == '0 && !berr_o)); // R2

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R3

  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0 && busy_i) |=> grant_o == '0); // R3

  AST_NO_GRANT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0 && rst_hold) |=> grant_o == '0); // R3

  AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && busy_i) |=> grant_o == '0); // R4

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !busy_i && (grant_o & req_i) != '0 && en_strap_i &&
     !rst_hold && !lreset_req_i) |=> $stable(grant_o)); // R4

  AST_SINGLE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (single_lvl_i && grant_o == '0) |=> grant_o[N_LVL-2:0] == '0); // R6

  AST_TMO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sel_i == '1 && !berr_o) |=> !berr_o); // R8

  AST_BERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_o && dstrobe_i && en_strap_i && !rst_hold && !lreset_req_i) |=> berr_o); // R9

  AST_BERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !dstrobe_i |=> !berr_o); // R9

  AST_ACK_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (sack_i && !berr_o) |=> !berr_o); // R10

  AST_LED_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> arb_led_o); // R11

endmodule

bind bsc_sysctl bsc_sysctl_chk #(.N_LVL(N_LVL), .SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_strap_i   (en_strap_i),
  .single_lvl_i (single_lvl_i),
  .tmo_sel_i    (tmo_sel_i),
  .lreset_req_i (lreset_req_i),
  .req_i        (req_i),
  .busy_i       (busy_i),
  .dstrobe_i    (dstrobe_i),
  .sack_i       (sack_i),
  .grant_o      (grant_o),
  .berr_o       (berr_o),
  .bus_reset_o  (bus_reset_o),
  .arb_led_o    (arb_led_o),
  .grant_fire   (grant_fire),
  .rst_hold     (rst_hold)
);

// File: tb/bsc_sysctl_tb.sv
module bsc_sysctl_tb;

  localparam int N_LVL   = 4;
  localparam int SEL_W   = 3;
  localparam int RST_MIN = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en_strap_i = 1'b1;
  logic             single_lvl_i = 1'b0;
  logic [SEL_W-1:0] tmo_sel_i = '0;
  logic             lreset_req_i = 1'b0;
  logic [N_LVL-1:0] req_i = '0;
  logic             busy_i = 1'b0;
  logic             dstrobe_i = 1'b0;
  logic             sack_i = 1'b0;
  logic             tick_i = 1'b0;
  logic [N_LVL-1:0] grant_o;
  logic             berr_o;
  logic             bus_reset_o;
  logic             arb_led_o;
  logic             sysctl_on_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bsc_sysctl #(.N_LVL(N_LVL), .SEL_W(SEL_W), .RST_MIN(RST_MIN)) u_dut (
    .clk, .rst_n, .en_strap_i, .single_lvl_i, .tmo_sel_i, .lreset_req_i,
    .req_i, .busy_i, .dstrobe_i, .sack_i, .tick_i,
    .grant_o, .berr_o, .bus_reset_o, .arb_led_o, .sysctl_on_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  // Expect a grant to level lvl, then take and release the bus.
  task automatic serve(input int lvl);
    step();
    check("R5 rr grant", 32'(grant_o), 32'(1 << lvl));
    check("R11 led on", 32'(arb_led_o), 1);
    busy_i = 1'b1;
    step();
    check("R4 drop on busy", 32'(grant_o), 0);
    check("R11 led off", 32'(arb_led_o), 0);
    busy_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) step();
    check("R1 reset active", 32'(bus_reset_o), 1);
    check("R3 no grant in reset", 32'(grant_o), 0);
    check("R2 strap readback", 32'(sysctl_on_o), 1);
    rst_n = 1'b1;
    repeat (RST_MIN - 1) @(posedge clk);
    @(negedge clk);
    check("R1 stretch tail", 32'(bus_reset_o), 1);
    step();
    check("R1 stretch end", 32'(bus_reset_o), 0);
  endtask

  task automatic t_round_robin();
    req_i = 4'b1111;
    serve(3); serve(0); serve(1); serve(2); serve(3);
    req_i = 4'b0101;
    serve(0); serve(2); serve(0);
    req_i = '0;
    step();
  endtask

  task automatic t_busy_block();
    busy_i = 1'b1;
    req_i  = 4'b0010;
    repeat (3) begin
      step();
      check("R3 no grant while busy", 32'(grant_o), 0);
    end
    busy_i = 1'b0;
    serve(1);
    req_i = '0;
    step();
  endtask

  task automatic t_withdraw();
    req_i = 4'b0100;
    step();
    check("R4 granted", 32'(grant_o), 32'h4);
    step();
    check("R4 held while idle", 32'(grant_o), 32'h4);
    req_i = '0;
    step();
    check("R4 drop on withdraw", 32'(grant_o), 0);
    check("R11 led off", 32'(arb_led_o), 0);
  endtask

  task automatic t_single();
    single_lvl_i = 1'b1;
    req_i = 4'b0111;
    repeat (4) begin
      step();
      check("R6 low levels ignored", 32'(grant_o), 0);
    end
    req_i = 4'b1111;
    serve(3);
    req_i = '0;
    single_lvl_i = 1'b0;
    step();
  endtask

  task automatic t_strap_off();
    en_strap_i = 1'b0;
    req_i = 4'b1111;
    tmo_sel_i = '0;
    dstrobe_i = 1'b1;
    step();
    check("R2 readback off", 32'(sysctl_on_o), 0);
    for (int i = 0; i < 20; i++) pulse_tick();
    check("R2 no grant", 32'(grant_o), 0);
    check("R2 no berr", 32'(berr_o), 0);
    lreset_req_i = 1'b1;
    step();
    lreset_req_i = 1'b0;
    check("R2 no bus reset", 32'(bus_reset_o), 0);
    dstrobe_i = 1'b0;
    req_i = '0;
    repeat (RST_MIN + 1) step();
    en_strap_i = 1'b1;
    step();
  endtask

  task automatic t_timeout(input int sel);
    int lim;
    lim = 16 << sel;
    tmo_sel_i = SEL_W'(sel);
    dstrobe_i = 1'b1;
    step();
    for (int i = 0; i < lim - 1; i++) pulse_tick();
    check("R7 before limit", 32'(berr_o), 0);
    pulse_tick();
    check("R7 at limit", 32'(berr_o), 1);
    repeat (3) step();
    check("R9 berr held", 32'(berr_o), 1);
    dstrobe_i = 1'b0;
    step();
    check("R9 berr cleared", 32'(berr_o), 0);
  endtask

  task automatic t_disabled();
    tmo_sel_i = 3'd7;
    dstrobe_i = 1'b1;
    step();
    for (int i = 0; i < 1100; i++) pulse_tick();
    check("R8 disabled", 32'(berr_o), 0);
    dstrobe_i = 1'b0;
    step();
  endtask

  task automatic t_ack();
    tmo_sel_i = '0;
    dstrobe_i = 1'b1;
    step();
    for (int i = 0; i < 8; i++) pulse_tick();
    sack_i = 1'b1;
    for (int i = 0; i < 30; i++) pulse_tick();
    check("R10 acked no berr", 32'(berr_o), 0);
    sack_i = 1'b0;
    dstrobe_i = 1'b0;
    step();
  endtask

  task automatic t_restart();
    tmo_sel_i = '0;
    dstrobe_i = 1'b1;
    step();
    for (int i = 0; i < 10; i++) pulse_tick();
    dstrobe_i = 1'b0;
    step();
    dstrobe_i = 1'b1;
    step();
    for (int i = 0; i < 10; i++) pulse_tick();
    check("R9 count restarted", 32'(berr_o), 0);
    for (int i = 0; i < 5; i++) pulse_tick();
    check("R9 one short", 32'(berr_o), 0);
    pulse_tick();
    check("R9 fresh limit", 32'(berr_o), 1);
    dstrobe_i = 1'b0;
    step();
  endtask

  task automatic t_local_reset();
    req_i = 4'b1000;
    lreset_req_i = 1'b1;
    step();
    lreset_req_i = 1'b0;
    check("R1 local reset on", 32'(bus_reset_o), 1);
    for (int j = 1; j < RST_MIN; j++) begin
      step();
      check("R3 no grant in bus reset", 32'(grant_o), 0);
    end
    check("R1 local stretch tail", 32'(bus_reset_o), 1);
    step();
    check("R1 local stretch end", 32'(bus_reset_o), 0);
    check("R3 still no grant", 32'(grant_o), 0);
    serve(3);
    req_i = '0;
    step();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_round_robin();
    t_busy_block();
    t_withdraw();
    t_single();
    t_strap_off();
    t_timeout(0);
    t_timeout(1);
    t_timeout(3);
    t_timeout(6);
    t_disabled();
    t_ack();
    t_restart();
    t_local_reset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule